// File: doc/BRIEF.md
# Path-Tagged Prediction Cache

This block holds branch outcomes computed ahead of time by helper microthreads and hands them to the fetch stage. Each stored outcome is keyed by two fields: a hash of the control-flow path leading to the branch, and the dynamic sequence number of the one branch instance it is meant for. A writer gives its spawn sequence number and a separation distance. The block adds the two to form the target sequence number, then stores the predicted direction and target.

The fetch stage looks up every branch with its current path hash and sequence number, together with the prediction the hardware predictor made. One cycle later the block returns the prediction to use. On a hit this is the stored outcome; on a miss it is the hardware prediction passed through. A write and a lookup for the same key in the same cycle forward the write's outcome to the lookup.

Missed lookups are remembered in a small in-flight table. A write whose target is already behind the fetch position is late. A late write is checked against the in-flight table. If it finds the branch there and disagrees with the prediction that branch used, the block raises an early-recovery pulse carrying the corrected outcome. Stored entries are freed once they fall behind the fetch position. In-flight records are freed once they fall behind the resolve position. Every age comparison is modulo, so it stays correct when sequence numbers wrap.

Top module: `path_pred_cache`

## Requirements
- R1: After reset the store and the in-flight table are empty: no lookup hits and no recovery pulse is raised.
- R2: A write stores its outcome at sequence number spawn + separation (modulo 2^SEQ_W). A later lookup with the same path hash and that sequence number returns lk_hit_o=1, with the written direction and target, one cycle after the lookup.
- R3: A lookup that differs in the path hash or in the sequence number misses. It returns lk_hit_o=0 and passes the supplied hardware direction and target through one cycle later.
- R4: A write and a lookup for the same key in the same cycle give a hit with the write's outcome.
- R5: A write to a key already stored replaces that entry's outcome in place and takes no new slot.
- R6: A stored entry whose sequence number is older than fe_seq_i is freed at the next clock edge. An entry equal to fe_seq_i is kept.
- R7: A write that finds no free slot and no matching key evicts the valid entry with the oldest sequence number.
- R8: Ages are taken from the sign of the SEQ_W-bit difference, so the oldest-entry choice and the freeing rule hold across wrap-around. Examples: 0xFFFE is older than 0x0000, and 0x0001 is not older than 0xFFF0.
- R9: A late write (target older than fe_seq_i) that matches an in-flight record raises rcv_valid_o for one cycle, on the cycle after the write, when it disagrees with that record. Disagreeing means the directions differ, or both are taken (direction bit 1) with different targets. The pulse carries the write's sequence number, path, direction and target.
- R10: A late write is never stored. It raises no recovery when it agrees with the in-flight record, when both directions are not-taken, or when it matches no record.
- R11: An in-flight record whose sequence number is older than rs_seq_i is freed. A late write after that raises no recovery.
- R12: An in-flight record is consumed by the first late write that matches it, so a repeated late write raises no recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Microthread outcome write strobe |
| wr_path_i | input | PATH_W | Path hash of the predicted branch |
| wr_spawn_seq_i | input | SEQ_W | Sequence number at the spawn point |
| wr_sep_i | input | SEQ_W | Distance from spawn to the predicted branch |
| wr_taken_i | input | 1 | Predicted direction, 1 = taken |
| wr_target_i | input | TGT_W | Predicted target |
| lk_valid_i | input | 1 | Fetch lookup strobe |
| lk_path_i | input | PATH_W | Path hash of the fetched branch |
| lk_seq_i | input | SEQ_W | Sequence number of the fetched branch |
| lk_hw_taken_i | input | 1 | Hardware predictor direction |
| lk_hw_target_i | input | TGT_W | Hardware predictor target |
| lk_hit_o | output | 1 | Lookup hit on both key fields |
| lk_taken_o | output | 1 | Direction to use |
| lk_target_o | output | TGT_W | Target to use |
| fe_seq_i | input | SEQ_W | Current fetch sequence position |
| rs_seq_i | input | SEQ_W | Oldest unresolved sequence position |
| rcv_valid_o | output | 1 | Early-recovery pulse |
| rcv_seq_o | output | SEQ_W | Sequence number of the branch to recover |
| rcv_path_o | output | PATH_W | Path hash of the branch to recover |
| rcv_taken_o | output | 1 | Corrected direction |
| rcv_target_o | output | TGT_W | Corrected target |

## Verification
The hardest case to reach from the ports is an early recovery. It needs a lookup that misses while its sequence number is still current, then a rise of fe_seq_i past that number, and only then a write to the same key. The bench builds that ordering step by step, then varies it: a disagreement in direction alone, a disagreement in target alone, agreement, a repeat of the same late write, and a record already retired through rs_seq_i. Eviction of the oldest entry is reached with a four-entry instance filled in a scrambled order and across the sequence wrap.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_STORE = 2'd1,
    WR_LATE  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/ptpc_oldest.sv
module ptpc_oldest #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][SEQ_W-1:0] seq_i,
  output logic [IDX_W-1:0]        idx_o
);
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [SEQ_W-1:0] best;

  // linear scan; chain depth grows with N
  always_comb begin
    best  = seq_i[0];
    idx_o = '0;
    for (int i = 1; i < N; i++) begin
      if (older(seq_i[i], best)) begin
        best  = seq_i[i];
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ptpc_store.sv
module ptpc_store #(
  parameter int N      = 128,
  parameter int PATH_W = 16,
  parameter int SEQ_W  = 16,
  parameter int TGT_W  = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PATH_W-1:0] wr_path_i,
  input  logic [SEQ_W-1:0]  wr_seq_i,
  input  logic              wr_taken_i,
  input  logic [TGT_W-1:0]  wr_target_i,
  input  logic [PATH_W-1:0] lk_path_i,
  input  logic [SEQ_W-1:0]  lk_seq_i,
  input  logic [SEQ_W-1:0]  fe_seq_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [TGT_W-1:0]  lk_target_o
);
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [N-1:0]             valid_q;
  logic [N-1:0][PATH_W-1:0] path_q;
  logic [N-1:0][SEQ_W-1:0]  seq_q;
  logic [N-1:0]             taken_q;
  logic [N-1:0][TGT_W-1:0]  tgt_q;

  logic [N-1:0] wr_match, lk_match, stale;
  logic [IDX_W-1:0] wr_idx, match_idx, free_idx, old_idx;
  logic any_match, any_free;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign wr_match[g] = valid_q[g] && path_q[g] == wr_path_i && seq_q[g] == wr_seq_i;
    assign lk_match[g] = valid_q[g] && path_q[g] == lk_path_i && seq_q[g] == lk_seq_i;
    assign stale[g]    = valid_q[g] && older(seq_q[g], fe_seq_i);
  end

  ptpc_oldest #(.N(N), .SEQ_W(SEQ_W)) u_victim (
    .seq_i (seq_q),
    .idx_o (old_idx)
  );

  // same key first, then lowest free slot, then oldest entry
  always_comb begin
    any_match = 1'b0;
    match_idx = '0;
    any_free  = 1'b0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (wr_match[i]) begin
        any_match = 1'b1;
        match_idx = IDX_W'(i);
      end
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    wr_idx = any_match ? match_idx : (any_free ? free_idx : old_idx);
  end

  always_comb begin
    lk_hit_o    = 1'b0;
    lk_taken_o  = 1'b0;
    lk_target_o = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_hit_o    = 1'b1;
        lk_taken_o  = taken_q[i];
        lk_target_o = tgt_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~stale;
      if (wr_en_i) valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      path_q[wr_idx]  <= wr_path_i;
      seq_q[wr_idx]   <= wr_seq_i;
      taken_q[wr_idx] <= wr_taken_i;
      tgt_q[wr_idx]   <= wr_target_i;
    end
  end
endmodule

// File: rtl/ptpc_flight.sv
module ptpc_flight #(
  parameter int N      = 16,
  parameter int PATH_W = 16,
  parameter int SEQ_W  = 16,
  parameter int TGT_W  = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_en_i,
  input  logic [PATH_W-1:0] ins_path_i,
  input  logic [SEQ_W-1:0]  ins_seq_i,
  input  logic              ins_taken_i,
  input  logic [TGT_W-1:0]  ins_target_i,
  input  logic              chk_en_i,
  input  logic [PATH_W-1:0] chk_path_i,
  input  logic [SEQ_W-1:0]  chk_seq_i,
  input  logic              chk_taken_i,
  input  logic [TGT_W-1:0]  chk_target_i,
  input  logic [SEQ_W-1:0]  rs_seq_i,
  output logic              mis_o
);
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic [N-1:0]             valid_q;
  logic [N-1:0][PATH_W-1:0] path_q;
  logic [N-1:0][SEQ_W-1:0]  seq_q;
  logic [N-1:0]             taken_q;
  logic [N-1:0][TGT_W-1:0]  tgt_q;

  logic [N-1:0] hit, done;
  logic [IDX_W-1:0] ins_idx, free_idx, old_idx;
  logic any_free;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g]  = chk_en_i && valid_q[g] && path_q[g] == chk_path_i && seq_q[g] == chk_seq_i;
    assign done[g] = valid_q[g] && older(seq_q[g], rs_seq_i);
  end

  ptpc_oldest #(.N(N), .SEQ_W(SEQ_W)) u_victim (
    .seq_i (seq_q),
    .idx_o (old_idx)
  );

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    mis_o    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (hit[i] && (taken_q[i] != chk_taken_i ||
                     (chk_taken_i && tgt_q[i] != chk_target_i))) begin
        mis_o = 1'b1;
      end
    end
    ins_idx = any_free ? free_idx : old_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~done & ~hit;
      if (ins_en_i) valid_q[ins_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_en_i) begin
      path_q[ins_idx]  <= ins_path_i;
      seq_q[ins_idx]   <= ins_seq_i;
      taken_q[ins_idx] <= ins_taken_i;
      tgt_q[ins_idx]   <= ins_target_i;
    end
  end
endmodule

// File: rtl/path_pred_cache.sv
module path_pred_cache
  import ptpc_pkg::*;
#(
  parameter int N_ENTRIES = 128,
  parameter int FL_N      = 16,
  parameter int PATH_W    = 16,
  parameter int SEQ_W     = 16,
  parameter int TGT_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [PATH_W-1:0] wr_path_i,
  input  logic [SEQ_W-1:0]  wr_spawn_seq_i,
  input  logic [SEQ_W-1:0]  wr_sep_i,
  input  logic              wr_taken_i,
  input  logic [TGT_W-1:0]  wr_target_i,
  input  logic              lk_valid_i,
  input  logic [PATH_W-1:0] lk_path_i,
  input  logic [SEQ_W-1:0]  lk_seq_i,
  input  logic              lk_hw_taken_i,
  input  logic [TGT_W-1:0]  lk_hw_target_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [TGT_W-1:0]  lk_target_o,
  input  logic [SEQ_W-1:0]  fe_seq_i,
  input  logic [SEQ_W-1:0]  rs_seq_i,
  output logic              rcv_valid_o,
  output logic [SEQ_W-1:0]  rcv_seq_o,
  output logic [PATH_W-1:0] rcv_path_o,
  output logic              rcv_taken_o,
  output logic [TGT_W-1:0]  rcv_target_o
);
  logic [SEQ_W-1:0] tgt_seq, age;
  wr_kind_e wr_kind;
  logic fwd, hit_now, st_hit, st_taken, fl_mis;
  logic [TGT_W-1:0] st_target;

  assign tgt_seq = wr_spawn_seq_i + wr_sep_i;
  assign age     = tgt_seq - fe_seq_i;

  always_comb begin
    if (!wr_valid_i)      wr_kind = WR_NONE;
    else if (age[SEQ_W-1]) wr_kind = WR_LATE;
    else                  wr_kind = WR_STORE;
  end

  assign fwd     = lk_valid_i && wr_valid_i && wr_path_i == lk_path_i && tgt_seq == lk_seq_i;
  assign hit_now = fwd || st_hit;

  ptpc_store #(
    .N(N_ENTRIES), .PATH_W(PATH_W), .SEQ_W(SEQ_W), .TGT_W(TGT_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_kind == WR_STORE),
    .wr_path_i   (wr_path_i),
    .wr_seq_i    (tgt_seq),
    .wr_taken_i  (wr_taken_i),
    .wr_target_i (wr_target_i),
    .lk_path_i   (lk_path_i),
    .lk_seq_i    (lk_seq_i),
    .fe_seq_i    (fe_seq_i),
    .lk_hit_o    (st_hit),
    .lk_taken_o  (st_taken),
    .lk_target_o (st_target)
  );

  ptpc_flight #(
    .N(FL_N), .PATH_W(PATH_W), .SEQ_W(SEQ_W), .TGT_W(TGT_W)
  ) u_flight (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ins_en_i     (lk_valid_i && !hit_now),
    .ins_path_i   (lk_path_i),
    .ins_seq_i    (lk_seq_i),
    .ins_taken_i  (lk_hw_taken_i),
    .ins_target_i (lk_hw_target_i),
    .chk_en_i     (wr_kind == WR_LATE),
    .chk_path_i   (wr_path_i),
    .chk_seq_i    (tgt_seq),
    .chk_taken_i  (wr_taken_i),
    .chk_target_i (wr_target_i),
    .rs_seq_i     (rs_seq_i),
    .mis_o        (fl_mis)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o     <= 1'b0;
      lk_taken_o   <= 1'b0;
      lk_target_o  <= '0;
      rcv_valid_o  <= 1'b0;
      rcv_seq_o    <= '0;
      rcv_path_o   <= '0;
      rcv_taken_o  <= 1'b0;
      rcv_target_o <= '0;
    end else begin
      lk_hit_o <= lk_valid_i && hit_now;
      if (fwd) begin
        lk_taken_o  <= wr_taken_i;
        lk_target_o <= wr_target_i;
      end else if (st_hit) begin
        lk_taken_o  <= st_taken;
        lk_target_o <= st_target;
      end else begin
        lk_taken_o  <= lk_hw_taken_i;
        lk_target_o <= lk_hw_target_i;
      end
      rcv_valid_o <= (wr_kind == WR_LATE) && fl_mis;
      if (wr_kind == WR_LATE) begin
        rcv_seq_o    <= tgt_seq;
        rcv_path_o   <= wr_path_i;
        rcv_taken_o  <= wr_taken_i;
        rcv_target_o <= wr_target_i;
      end
    end
  end
endmodule

// File: rtl/ptpc_chk.sv
module ptpc_chk #(
  parameter int PATH_W = 16,
  parameter int SEQ_W  = 16,
  parameter int TGT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [PATH_W-1:0] wr_path_i,
  input logic [SEQ_W-1:0]  wr_spawn_seq_i,
  input logic [SEQ_W-1:0]  wr_sep_i,
  input logic              wr_taken_i,
  input logic              lk_valid_i,
  input logic [PATH_W-1:0] lk_path_i,
  input logic [SEQ_W-1:0]  lk_seq_i,
  input logic              lk_hw_taken_i,
  input logic [TGT_W-1:0]  lk_hw_target_i,
  input logic              lk_hit_o,
  input logic              lk_taken_o,
  input logic [TGT_W-1:0]  lk_target_o,
  input logic [SEQ_W-1:0]  fe_seq_i,
  input logic              rcv_valid_o,
  input logic [SEQ_W-1:0]  rcv_seq_o
);
  logic [SEQ_W-1:0] c_tgt, c_age;
  logic c_late;
  assign c_tgt  = wr_spawn_seq_i + wr_sep_i;
  assign c_age  = c_tgt - fe_seq_i;
  assign c_late = wr_valid_i && c_age[SEQ_W-1];

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> $past(lk_valid_i)); // R2

  AST_MISS_PASSES_HW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lk_valid_i) && !lk_hit_o) |->
      (lk_taken_o == $past(lk_hw_taken_i) && lk_target_o == $past(lk_hw_target_i))); // R3

  AST_SAME_CYCLE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && wr_valid_i && lk_path_i == wr_path_i && lk_seq_i == c_tgt) |=>
      (lk_hit_o && lk_taken_o == $past(wr_taken_i))); // R4

  AST_RCV_ONLY_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_valid_o |-> $past(c_late)); // R9

  AST_RCV_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_valid_o |-> rcv_seq_o == $past(c_tgt)); // R9
endmodule

bind path_pred_cache ptpc_chk #(.PATH_W(PATH_W), .SEQ_W(SEQ_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/sim_path_pred_cache.sv
module sim_path_pred_cache;
  localparam int PW = 16;
  localparam int SW = 16;
  localparam int TW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [PW-1:0] wr_path_i = '0;
  logic [SW-1:0] wr_spawn_seq_i = '0, wr_sep_i = '0;
  logic wr_taken_i = 1'b0;
  logic [TW-1:0] wr_target_i = '0;
  logic lk_valid_i = 1'b0;
  logic [PW-1:0] lk_path_i = '0;
  logic [SW-1:0] lk_seq_i = '0;
  logic lk_hw_taken_i = 1'b0;
  logic [TW-1:0] lk_hw_target_i = '0;
  logic lk_hit_o, lk_taken_o;
  logic [TW-1:0] lk_target_o;
  logic [SW-1:0] fe_seq_i = '0, rs_seq_i = '0;
  logic rcv_valid_o, rcv_taken_o;
  logic [SW-1:0] rcv_seq_o;
  logic [PW-1:0] rcv_path_o;
  logic [TW-1:0] rcv_target_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  path_pred_cache #(.N_ENTRIES(4), .FL_N(2), .PATH_W(PW), .SEQ_W(SW), .TGT_W(TW)) u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    wr_valid_i = 1'b0;
    lk_valid_i = 1'b0;
  endtask

  task automatic set_wr(input logic [PW-1:0] p, input logic [SW-1:0] s, input logic [SW-1:0] d,
                        input logic t, input logic [TW-1:0] g);
    wr_valid_i = 1'b1; wr_path_i = p; wr_spawn_seq_i = s; wr_sep_i = d;
    wr_taken_i = t; wr_target_i = g;
  endtask

  task automatic set_lk(input logic [PW-1:0] p, input logic [SW-1:0] s, input logic t,
                        input logic [TW-1:0] g);
    lk_valid_i = 1'b1; lk_path_i = p; lk_seq_i = s; lk_hw_taken_i = t; lk_hw_target_i = g;
  endtask

  task automatic write(input logic [PW-1:0] p, input logic [SW-1:0] s, input logic [SW-1:0] d,
                       input logic t, input logic [TW-1:0] g);
    set_wr(p, s, d, t, g);
    tick();
  endtask

  task automatic look(input string req, input logic [PW-1:0] p, input logic [SW-1:0] s,
                      input logic ht, input logic [TW-1:0] hg,
                      input logic eh, input logic et, input logic [TW-1:0] eg);
    set_lk(p, s, ht, hg);
    tick();
    chk(req, "hit", 32'(lk_hit_o), 32'(eh));
    chk(req, "taken", 32'(lk_taken_o), 32'(et));
    chk(req, "target", lk_target_o, eg);
  endtask

  task automatic do_reset(input logic [SW-1:0] fe, input logic [SW-1:0] rs);
    rst_ni = 1'b0;
    fe_seq_i = fe;
    rs_seq_i = rs;
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(16'd0, 16'd0);
    chk("R1", "hit after reset", 32'(lk_hit_o), 0);
    chk("R1", "rcv after reset", 32'(rcv_valid_o), 0);
    look("R1", 16'h5, 16'd3, 1'b1, 32'h99, 1'b0, 1'b1, 32'h99);
    write(16'h5, 16'd0, 16'd3, 1'b0, 32'h1);
    chk("R1", "rcv idle", 32'(rcv_valid_o), 0);
  endtask

  task automatic t_basic();
    do_reset(16'd100, 16'd0);
    write(16'h11, 16'd100, 16'd20, 1'b1, 32'hA0);
    write(16'h22, 16'd105, 16'd5, 1'b0, 32'h0);
    look("R2", 16'h11, 16'd120, 1'b0, 32'h0, 1'b1, 1'b1, 32'hA0);
    look("R2", 16'h22, 16'd110, 1'b1, 32'h7, 1'b1, 1'b0, 32'h0);
    look("R3", 16'h11, 16'd121, 1'b1, 32'h55, 1'b0, 1'b1, 32'h55);
    look("R3", 16'h12, 16'd120, 1'b0, 32'h66, 1'b0, 1'b0, 32'h66);
  endtask

  task automatic t_fwd();
    do_reset(16'd50, 16'd0);
    set_wr(16'h33, 16'd90, 16'd40, 1'b1, 32'hC0);
    set_lk(16'h33, 16'd130, 1'b0, 32'h0);
    tick();
    chk("R4", "fwd hit", 32'(lk_hit_o), 1);
    chk("R4", "fwd taken", 32'(lk_taken_o), 1);
    chk("R4", "fwd target", lk_target_o, 32'hC0);
  endtask

  task automatic t_overwrite();
    do_reset(16'd0, 16'd0);
    for (int i = 0; i < 4; i++) write(16'(i + 1), 16'd10, 16'(i), 1'b1, 32'(i));
    for (int i = 0; i < 5; i++) write(16'd1, 16'd10, 16'd0, 1'b0, 32'(32'hB0 + i));
    look("R5", 16'd1, 16'd10, 1'b1, 32'h0, 1'b1, 1'b0, 32'hB4);
    for (int i = 1; i < 4; i++) look("R5", 16'(i + 1), 16'(10 + i), 1'b0, 32'h0, 1'b1, 1'b1, 32'(i));
  endtask

  task automatic t_stale();
    do_reset(16'd100, 16'd0);
    write(16'h44, 16'd100, 16'd10, 1'b1, 32'h44);
    write(16'h45, 16'd100, 16'd11, 1'b1, 32'h45);
    look("R6", 16'h44, 16'd110, 1'b0, 32'h0, 1'b1, 1'b1, 32'h44);
    fe_seq_i = 16'd111;
    tick();
    look("R6", 16'h44, 16'd110, 1'b0, 32'h3, 1'b0, 1'b0, 32'h3);
    look("R6", 16'h45, 16'd111, 1'b0, 32'h0, 1'b1, 1'b1, 32'h45);
  endtask

  task automatic t_evict();
    do_reset(16'd0, 16'd0);
    write(16'd22, 16'd0, 16'd22, 1'b1, 32'd22);
    write(16'd20, 16'd0, 16'd20, 1'b1, 32'd20);
    write(16'd23, 16'd0, 16'd23, 1'b1, 32'd23);
    write(16'd21, 16'd0, 16'd21, 1'b1, 32'd21);
    write(16'd24, 16'd0, 16'd24, 1'b1, 32'd24);
    look("R7", 16'd20, 16'd20, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    for (int s = 21; s <= 24; s++) look("R7", 16'(s), 16'(s), 1'b0, 32'h0, 1'b1, 1'b1, 32'(s));
  endtask

  task automatic t_wrap();
    do_reset(16'hFFF0, 16'hFFF0);
    write(16'h1, 16'hFFF0, 16'h0011, 1'b1, 32'h1);
    write(16'h2, 16'hFFF0, 16'h000E, 1'b1, 32'h2);
    write(16'h3, 16'hFFF0, 16'h0010, 1'b1, 32'h3);
    write(16'h4, 16'hFFF0, 16'h000F, 1'b1, 32'h4);
    write(16'h5, 16'hFFF0, 16'h0012, 1'b1, 32'h5);
    look("R8", 16'h2, 16'hFFFE, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    look("R8", 16'h1, 16'h0001, 1'b0, 32'h0, 1'b1, 1'b1, 32'h1);
    look("R8", 16'h5, 16'h0002, 1'b0, 32'h0, 1'b1, 1'b1, 32'h5);
    look("R8", 16'h4, 16'hFFFF, 1'b0, 32'h0, 1'b1, 1'b1, 32'h4);
  endtask

  task automatic t_late();
    do_reset(16'd200, 16'd0);
    look("R9", 16'h66, 16'd200, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    fe_seq_i = 16'd201;
    write(16'h66, 16'd190, 16'd10, 1'b1, 32'hD0);
    chk("R9", "rcv valid", 32'(rcv_valid_o), 1);
    chk("R9", "rcv seq", 32'(rcv_seq_o), 200);
    chk("R9", "rcv path", 32'(rcv_path_o), 32'h66);
    chk("R9", "rcv taken", 32'(rcv_taken_o), 1);
    chk("R9", "rcv target", rcv_target_o, 32'hD0);
    tick();
    chk("R9", "rcv pulse ends", 32'(rcv_valid_o), 0);
    write(16'h66, 16'd190, 16'd10, 1'b1, 32'hD0);
    chk("R12", "repeat late write", 32'(rcv_valid_o), 0);
    look("R10", 16'h66, 16'd200, 1'b0, 32'h9, 1'b0, 1'b0, 32'h9);
  endtask

  task automatic t_agree();
    do_reset(16'd300, 16'd0);
    look("R10", 16'h77, 16'd300, 1'b1, 32'hE0, 1'b0, 1'b1, 32'hE0);
    fe_seq_i = 16'd301;
    write(16'h77, 16'd300, 16'd0, 1'b1, 32'hE0);
    chk("R10", "agree no rcv", 32'(rcv_valid_o), 0);
    look("R9", 16'h78, 16'd301, 1'b1, 32'hE0, 1'b0, 1'b1, 32'hE0);
    fe_seq_i = 16'd302;
    write(16'h78, 16'd301, 16'd0, 1'b1, 32'hE4);
    chk("R9", "target differs", 32'(rcv_valid_o), 1);
    look("R10", 16'h79, 16'd302, 1'b0, 32'h10, 1'b0, 1'b0, 32'h10);
    fe_seq_i = 16'd303;
    write(16'h79, 16'd302, 16'd0, 1'b0, 32'h20);
    chk("R10", "not taken both", 32'(rcv_valid_o), 0);
    write(16'h7A, 16'd250, 16'd0, 1'b1, 32'h1);
    chk("R10", "no record", 32'(rcv_valid_o), 0);
  endtask

  task automatic t_resolve();
    do_reset(16'd400, 16'd400);
    look("R11", 16'h88, 16'd400, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    fe_seq_i = 16'd401;
    rs_seq_i = 16'd401;
    tick();
    write(16'h88, 16'd400, 16'd0, 1'b1, 32'h8);
    chk("R11", "retired record", 32'(rcv_valid_o), 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
  end

  initial begin
    t_reset();
    t_basic();
    t_fwd();
    t_overwrite();
    t_stale();
    t_evict();
    t_wrap();
    t_late();
    t_agree();
    t_resolve();
    report();
  end
endmodule